// File: doc/BRIEF.md
# Fractional Baud Rate Generator

This block turns a fast reference clock into the two timing strobes a UART needs. The first is a one-cycle sample tick at the oversampling rate, and the second is a bit tick that marks each serial bit time. The rate is set by three byte-wide registers, each written through its own strobe over a shared data bus. Two of them hold the low and high halves of a 16-bit integer divisor. The third holds a 4-bit fraction in sixteenths in bits [3:0] and an oversampling select in bits [5:4].

The fraction works by lengthening some sample periods by one reference cycle. An accumulator adds the fraction on every sample tick, and each carry out of it adds one extra cycle. Over any 16 consecutive sample periods the total is therefore 16·D + F reference cycles. The bit tick coincides with every 16th, 8th or 4th sample tick, depending on the select field.

A small state machine drives the timing. It has three states: HALT (idle or restarting), COUNT (counting the integer part of a period) and EXTEND (the single extra cycle of a lengthened period). Its transitions are:
- *start*: HALT to COUNT, when the divisor is non-zero.
- *wrap*: COUNT to COUNT, at the end of a period that is not lengthened.
- *stretch*: COUNT to EXTEND, at the end of a period that is lengthened.
- *resume*: EXTEND to COUNT.
- *reload*: from any state to HALT, on any register write or on reset.

Top module: `baud_fracgen`

## Requirements
- R1: The integer divisor D is {high byte, low byte}. Each byte is loaded from `wr_data` in the cycle its strobe is high, and an unwritten byte keeps its value. All three registers reset to zero.
- R2: While D is zero, neither tick is ever asserted.
- R3: With fraction F = 0, `sample_tick` is high on exactly the last cycle of every D-cycle period.
- R4: Counting periods from 0 after a restart, period k lasts D + floor((k+1)·F/16) − floor(k·F/16) cycles, with k taken modulo 16. Any 16 consecutive periods therefore span 16·D + F cycles, and D = 1 with F = 15 gives two-cycle periods on 15 of every 16.
- R5: Bits [5:4] of the extended register select the ratio: 00 gives 16, 01 gives 8, 10 gives 4, and 11 gives 16. Bits [3:0] hold F, and bits [7:6] are ignored.
- R6: `bit_tick` is asserted only together with `sample_tick`. It fires on sample ticks number N, 2N, 3N and so on after a restart, where N is the selected ratio.
- R7: Any write moves the block to HALT at that edge. The cycle after the write never carries a tick, and period 0 starts on the following cycle, with the fraction phase and the bit phase both cleared.
- R8: During reset both ticks are low. After reset the block idles in HALT with D = 0, F = 0 and 16x selected.
- R9: When D ≥ 2, `sample_tick` is never high on two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_lo | input | 1 | Write strobe, divisor low byte |
| wr_hi | input | 1 | Write strobe, divisor high byte |
| wr_ext | input | 1 | Write strobe, fraction/select register |
| wr_data | input | 8 | Write data shared by the three strobes |
| sample_tick | output | 1 | One-cycle oversampling enable |
| bit_tick | output | 1 | One-cycle enable once per bit time |

## Verification
Several properties are checked by assertions on every cycle:
- no ticks with a zero divisor;
- bit ticks are a subset of sample ticks;
- a quiet cycle follows every write;
- no EXTEND state when the fraction is zero;
- single-cycle pulses for D ≥ 2;
- the oversampling counter stays in range;
- the accumulator holds between ticks.

The exact spacing of lengthened periods, the 16·D + F total, the bit-tick position for each select code and the behaviour of the high byte can only be shown by the bench scenarios. There, a behavioural period model is compared against both outputs on every clock.

// File: rtl/baud_fracgen_pkg.sv
package baud_fracgen_pkg;

    typedef enum logic [1:0] {
        ST_HALT   = 2'd0,
        ST_COUNT  = 2'd1,
        ST_EXTEND = 2'd2
    } gen_state_e;

    localparam int RATIO_W = 5;

    // Oversampling ratio for the 2-bit select field; code 3 falls back to 16.
    function automatic logic [RATIO_W-1:0] osr_ratio(input logic [1:0] sel);
        unique case (sel)
            2'd1:    osr_ratio = RATIO_W'(8);
            2'd2:    osr_ratio = RATIO_W'(4);
            default: osr_ratio = RATIO_W'(16);
        endcase
    endfunction

endpackage

// File: rtl/baud_fracgen_regs.sv
module baud_fracgen_regs #(
    parameter int BYTE_W = 8,
    parameter int FRAC_W = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_lo,
    input  logic                  wr_hi,
    input  logic                  wr_ext,
    input  logic [BYTE_W-1:0]     wr_data,
    output logic [2*BYTE_W-1:0]   divisor,
    output logic [FRAC_W-1:0]     frac,
    output logic [1:0]            osr_sel,
    output logic                  reload
);
    localparam int SEL_LSB = FRAC_W;

    logic [BYTE_W-1:0] lo_q, hi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q    <= '0;
            hi_q    <= '0;
            frac    <= '0;
            osr_sel <= '0;
        end else begin
            if (wr_lo)  lo_q <= wr_data;
            if (wr_hi)  hi_q <= wr_data;
            if (wr_ext) begin
                frac    <= wr_data[FRAC_W-1:0];
                osr_sel <= wr_data[SEL_LSB+1:SEL_LSB];
            end
        end
    end

    assign divisor = {hi_q, lo_q};
    assign reload  = wr_lo | wr_hi | wr_ext;

    // R1: unwritten divisor bytes hold their value
    p_div_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_lo && !wr_hi) |=> $stable(divisor));
    // R1: high byte takes the bus value
    p_hi_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi |=> (divisor[2*BYTE_W-1:BYTE_W] == $past(wr_data)));

endmodule

// File: rtl/baud_fracgen_acc.sv
module baud_fracgen_acc #(
    parameter int FRAC_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              advance,
    input  logic [FRAC_W-1:0] frac,
    output logic              stretch
);
    logic [FRAC_W-1:0] acc_q;
    logic [FRAC_W:0]   sum;

    assign sum     = {1'b0, acc_q} + {1'b0, frac};
    assign stretch = sum[FRAC_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       acc_q <= '0;
        else if (clear)   acc_q <= '0;
        else if (advance) acc_q <= sum[FRAC_W-1:0];
    end

    // R4: phase only moves on a sample tick
    p_acc_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !advance) |=> $stable(acc_q));

endmodule

// File: rtl/baud_fracgen_oscnt.sv
module baud_fracgen_oscnt #(
    parameter int CNT_W = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clear,
    input  logic           advance,
    input  logic [CNT_W:0] ratio,
    output logic           last
);
    logic [CNT_W-1:0] os_q;

    assign last = ({1'b0, os_q} == ratio - (CNT_W+1)'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       os_q <= '0;
        else if (clear)   os_q <= '0;
        else if (advance) os_q <= last ? '0 : os_q + CNT_W'(1);
    end

    // R6: sub-count never reaches the ratio
    p_os_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, os_q} < ratio));

endmodule

// File: rtl/baud_fracgen.sv
module baud_fracgen
    import baud_fracgen_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int FRAC_W = 4,
    parameter int OS_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic              wr_ext,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              sample_tick,
    output logic              bit_tick
);
    localparam int DIV_W = 2 * BYTE_W;

    gen_state_e         state_q, state_nx;
    logic [DIV_W-1:0]   divisor, cnt_q;
    logic [FRAC_W-1:0]  frac;
    logic [1:0]         osr_sel;
    logic               reload, stretch, os_last, at_end, start, phase_clr;
    logic [OS_W:0]      ratio;

    baud_fracgen_regs #(.BYTE_W(BYTE_W), .FRAC_W(FRAC_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_lo(wr_lo), .wr_hi(wr_hi),
        .wr_ext(wr_ext), .wr_data(wr_data), .divisor(divisor),
        .frac(frac), .osr_sel(osr_sel), .reload(reload)
    );

    assign start     = (state_q == ST_HALT) && (divisor != '0);
    assign phase_clr = reload | start;
    assign at_end    = (cnt_q == divisor - DIV_W'(1));
    assign ratio     = (OS_W+1)'(osr_ratio(osr_sel));

    baud_fracgen_acc #(.FRAC_W(FRAC_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .clear(phase_clr),
        .advance(sample_tick), .frac(frac), .stretch(stretch)
    );

    baud_fracgen_oscnt #(.CNT_W(OS_W)) u_os (
        .clk(clk), .rst_n(rst_n), .clear(phase_clr),
        .advance(sample_tick), .ratio(ratio), .last(os_last)
    );

    // next-state logic
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_HALT:   if (divisor != '0) state_nx = ST_COUNT;
            ST_COUNT:  if (at_end && stretch) state_nx = ST_EXTEND;
            ST_EXTEND: state_nx = ST_COUNT;
            default:   state_nx = ST_HALT;
        endcase
    end

    // state register and period counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HALT;
            cnt_q   <= '0;
        end else if (reload) begin
            state_q <= ST_HALT;
            cnt_q   <= '0;
        end else begin
            state_q <= state_nx;
            unique case (state_q)
                ST_COUNT: begin
                    if (!at_end)      cnt_q <= cnt_q + DIV_W'(1);
                    else if (!stretch) cnt_q <= '0;
                end
                default: cnt_q <= '0;
            endcase
        end
    end

    // outputs
    always_comb begin
        sample_tick = 1'b0;
        unique case (state_q)
            ST_COUNT:  sample_tick = at_end && !stretch;
            ST_EXTEND: sample_tick = 1'b1;
            default:   sample_tick = 1'b0;
        endcase
        bit_tick = sample_tick && os_last;
    end

    p_zero_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (divisor == '0) |-> !sample_tick);
    p_whole_no_ext_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (frac == '0 && !$past(reload)) |-> (state_q != ST_EXTEND));
    p_bit_in_sample_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> sample_tick);
    p_restart_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> !sample_tick);
    p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_tick && divisor > DIV_W'(1) && !reload) |=> !sample_tick);

endmodule

// File: tb/baud_fracgen_test.sv
module baud_fracgen_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_lo = 1'b0, wr_hi = 1'b0, wr_ext = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       sample_tick, bit_tick;

    baud_fracgen uut (
        .clk(clk), .rst_n(rst_n), .wr_lo(wr_lo), .wr_hi(wr_hi),
        .wr_ext(wr_ext), .wr_data(wr_data),
        .sample_tick(sample_tick), .bit_tick(bit_tick)
    );

    always #2 clk = ~clk;

    int    errors = 0, checks = 0, cyc = 0;
    bit    done = 0;
    string cur_req = "R8";
    int    st_seen = 0, bt_seen = 0;

    // behavioural model state
    int m_lo = 0, m_hi = 0, m_f = 0, m_sel = 0;
    int m_run = 0, m_el = 0, m_k = 0, m_os = 0;

    function automatic int m_div();
        return m_hi * 256 + m_lo;
    endfunction
    function automatic int m_ratio();
        return (m_sel == 1) ? 8 : (m_sel == 2) ? 4 : 16;
    endfunction
    function automatic int m_len(input int k);
        return m_div() + ((k + 1) * m_f) / 16 - (k * m_f) / 16;
    endfunction
    function automatic bit m_tick();
        return (m_run == 1) && (m_el == m_len(m_k));
    endfunction

    task automatic check_val(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input bit l, input bit h, input bit e, input logic [7:0] d);
        bit et, eb;
        @(negedge clk);
        et = m_tick();
        eb = et && (m_os == m_ratio() - 1);
        checks++;
        if (sample_tick !== et || bit_tick !== eb) begin
            errors++;
            $display("FAIL %s: sample=%0b bit=%0b expected sample=%0b bit=%0b",
                     cur_req, sample_tick, bit_tick, et, eb);
        end
        if (sample_tick === 1'b1) st_seen++;
        if (bit_tick === 1'b1) bt_seen++;
        wr_lo = l; wr_hi = h; wr_ext = e; wr_data = d;
        @(posedge clk);
        if (l || h || e) begin
            if (l) m_lo = d;
            if (h) m_hi = d;
            if (e) begin m_f = d[3:0]; m_sel = d[5:4]; end
            m_run = 0;
        end else if (m_run == 0) begin
            if (m_div() != 0) begin m_run = 1; m_el = 1; m_k = 0; m_os = 0; end
        end else if (et) begin
            m_el = 1; m_k = (m_k + 1) % 16; m_os = (m_os + 1) % m_ratio();
        end else begin
            m_el++;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 8'h00);
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0;
        wr_lo = 0; wr_hi = 0; wr_ext = 0;
        m_lo = 0; m_hi = 0; m_f = 0; m_sel = 0; m_run = 0;
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            check_val("R8 reset sample", int'(sample_tick), 0);
            check_val("R8 reset bit", int'(bit_tick), 0);
        end
        rst_n = 1'b1;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            errors++; checks++;
            $display("FAIL watchdog: got cycle %0d expected completion", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        apply_reset();
        cur_req = "R8"; idle(3);
        cur_req = "R2"; idle(20);               // zero divisor, no ticks

        cur_req = "R3";                          // D=5, F=0, 16x
        step(1, 0, 0, 8'd5);
        idle(120);

        cur_req = "R4";                          // D=5, F=3: 16 ticks in 1+83 cycles
        step(0, 0, 1, 8'h03);
        step(1, 0, 0, 8'd5);
        st_seen = 0;
        idle(1 + 16 * 5 + 3);
        check_val("R4 ticks in 16D+F window", st_seen, 16);
        idle(60);

        cur_req = "R4";                          // D=1, F=15 corner
        step(0, 0, 1, 8'h0F);
        step(1, 0, 0, 8'd1);
        st_seen = 0;
        idle(1 + 16 + 15);
        check_val("R4 D=1 F=15 ticks", st_seen, 16);

        cur_req = "R6";                          // D=2, 8x, F=0
        step(0, 0, 1, 8'h10);
        step(1, 0, 0, 8'd2);
        st_seen = 0; bt_seen = 0;
        idle(1 + 2 * 8 * 3);
        check_val("R6 sample count 8x", st_seen, 24);
        check_val("R6 bit count 8x", bt_seen, 3);

        cur_req = "R5";                          // 4x, F=7, reserved bits set
        step(0, 0, 1, 8'hE7);
        st_seen = 0; bt_seen = 0;
        idle(1 + 16 * 2 + 7);
        check_val("R5 4x bit count", bt_seen, 4);
        cur_req = "R5"; step(0, 0, 1, 8'h35);   // code 11 acts as 16x
        idle(200);
        cur_req = "R5"; step(0, 0, 1, 8'h00);   // back to 16x
        idle(80);

        cur_req = "R7";                          // mid-period rewrite
        step(1, 0, 0, 8'd3);
        idle(7);
        step(1, 0, 0, 8'd3);
        check_val("R7 quiet after write", int'(sample_tick), 0);
        idle(40);

        cur_req = "R1";                          // high byte: D=256
        step(0, 1, 0, 8'd1);
        step(1, 0, 0, 8'd0);
        st_seen = 0;
        idle(1 + 256);
        check_val("R1 one tick per 256", st_seen, 1);
        idle(300);

        cur_req = "R9";                          // D=2 with fraction
        step(0, 1, 0, 8'd0);
        step(1, 0, 0, 8'd2);
        step(0, 0, 1, 8'h09);
        idle(100);

        cur_req = "R2";                          // divisor cleared again
        step(1, 0, 0, 8'd0);
        st_seen = 0;
        idle(50);
        check_val("R2 no ticks with zero divisor", st_seen, 0);

        cur_req = "R8";                          // reset mid-run
        step(1, 0, 0, 8'd4);
        idle(10);
        apply_reset();
        st_seen = 0;
        idle(40);
        check_val("R8 idle after reset", st_seen, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule